// File: doc/BRIEF.md
# Dual-Output PWM Time Base

This block generates two pulse-width-modulated outputs, A and B, from one 16-bit time-base counter. A two-stage prescaler divides the system clock. The first stage divides by a power of two. The second stage divides by one or by an even number up to fourteen. Each prescaler tick advances the counter from zero up to a programmable period, after which it wraps back to zero. Software can also freeze the counter in place, or write a new value straight into it.

Each output has its own compare value and its own action settings. The zero event applies one action, and that output's compare-match event applies another. Each action can leave the output as it is, drive it low, drive it high or toggle it. The usual setup drives the output high at zero and toggles it on the match, which gives an edge-aligned duty cycle. The disabled setup drives the output low at zero instead.

The period register can take effect on the next cycle, or it can be held in a shadow copy until the next zero event. Configuration arrives on a plain write port with no back-pressure: a write presented in a cycle is accepted at that clock edge. The zero and compare events are also brought out as one-cycle strobes.

Top module: `pwm_timebase`

## Requirements
- R1: After reset all outputs are 0, the counter is 0 and frozen, the period and compares are 0, and every action is "none".
- R2: The control register (address 0) holds a coarse divider code c in bits [2:0] and a fine code f in bits [5:3]. While running, the counter advances once every N = 2^c * (f==0 ? 1 : 2f) clock cycles.
- R3: With control bit 6 set (run), each advance moves the counter from 0 up to the active period, and the advance after the period value returns it to 0.
- R4: With control bit 6 clear (freeze), the counter holds its value and the prescaler phase returns to 0.
- R5: A write to the counter register (address 4) loads the written value at that edge, overriding any advance, and restarts the prescaler phase.
- R6: On the edge that advances the counter, strobe zero_evt is raised for one cycle if the counter was 0. Strobe cmpa_evt is raised if the counter equalled compare A (address 2), and strobe cmpb_evt if it equalled compare B (address 3).
- R7: The action registers for A (address 5) and B (address 6) hold the zero action in bits [1:0] and the compare action in bits [3:2]. The codes are 0 none, 1 drive low, 2 drive high, 3 toggle. An output changes only on an edge where one of its events occurs, and A uses compare A while B uses compare B.
- R8: When the zero event and an output's compare event occur on the same edge, only the zero action is applied to that output.
- R9: With control bit 7 set (shadow), a write to the period register (address 1) is held and becomes active on the next zero event.
- R10: With control bit 7 clear, a period write becomes active at the write edge and governs the next wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| zero_evt | output | 1 | Counter-zero event strobe |
| cmpa_evt | output | 1 | Compare A event strobe |
| cmpb_evt | output | 1 | Compare B event strobe |
| count_o | output | 16 | Current time-base counter value |

## Verification
Every result is registered. A write, an advance, an event strobe and an output change all show on the ports one clock after the edge that causes them. The period write in shadow mode is the exception: it shows only after the next zero event. The bench drives each input just after a falling edge and steps a behavioural model once per rising edge. At the next falling edge it compares the counter, both outputs and all three strobes against that model, so no check depends on the order of events at a clock edge. The divider settings are changed mid-run to exercise several tick spacings, compare A is placed on zero to check priority, and the period is rewritten in both load modes.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_HIGH = 2'd2,
    ACT_FLIP = 2'd3
  } act_e;

  typedef struct packed {
    act_e on_cmp;   // bits [3:2]
    act_e on_zero;  // bits [1:0]
  } aq_cfg_t;

  localparam int ADDR_W = 3;
  localparam int NCH    = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_PRD  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPA = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_ACTA = 3'd5;

  localparam int CTRL_W       = 8;
  localparam int CTRL_RUN_BIT = 6;
  localparam int CTRL_SHD_BIT = 7;

  function automatic logic apply_act(act_e a, logic cur);
    case (a)
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      ACT_FLIP: return ~cur;
      default:  return cur;
    endcase
  endfunction
endpackage

// File: rtl/pwmtb_prescale.sv
module pwmtb_prescale #(
  parameter int C_W = 3,
  parameter int F_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_i,
  input  logic           restart_i,
  input  logic [C_W-1:0] coarse_i,
  input  logic [F_W-1:0] fine_i,
  output logic           tick_o
);
  localparam int FD_W  = F_W + 1;
  localparam int DIV_W = FD_W + (1 << C_W) - 1;

  logic [FD_W-1:0]  fine_div;
  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] pre_q;

  always_comb begin
    fine_div = (fine_i == '0) ? FD_W'(1) : {fine_i, 1'b0};
    div      = DIV_W'(fine_div) << coarse_i;
  end

  assign tick_o = run_i && (pre_q >= div - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              pre_q <= '0;
    else if (!run_i || restart_i || tick_o) pre_q <= '0;
    else                                     pre_q <= pre_q + DIV_W'(1);
  end

  // R2: after a tick the phase starts again from zero
  a_r2_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> pre_q == '0);
  // R4: frozen time base holds the phase at zero
  a_r4_phase_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> pre_q == '0);
endmodule

// File: rtl/pwmtb_timebase.sv
module pwmtb_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic         shadow_i,
  input  logic         prd_wr_i,
  input  logic         cnt_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, prd_q, shd_q;

  assign zero_o = tick_i && (cnt_q == '0);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (cnt_wr_i) cnt_q <= wdata_i;
    else if (tick_i)   cnt_q <= (cnt_q == prd_q) ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
      prd_q <= '0;
    end else begin
      if (prd_wr_i) shd_q <= wdata_i;
      if (prd_wr_i && !shadow_i)    prd_q <= wdata_i;
      else if (zero_o && shadow_i)  prd_q <= shd_q;
    end
  end

  // R4: frozen counter holds unless written
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !cnt_wr_i) |=> $stable(cnt_q));
  // R5: direct write lands at the write edge
  a_r5_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |=> cnt_q == $past(wdata_i));
  // R3: advance at the period value wraps to zero
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !cnt_wr_i && cnt_q == prd_q) |=> cnt_q == '0);
  // R9: in shadow mode the active period moves only on a zero event
  a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_i && !zero_o) |=> $stable(prd_q));
endmodule

// File: rtl/pwmtb_aq.sv
module pwmtb_aq
  import pwmtb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    zero_i,
  input  logic    match_i,
  input  aq_cfg_t cfg_i,
  output logic    pwm_o
);
  logic pwm_q;
  assign pwm_o = pwm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pwm_q <= 1'b0;
    else if (zero_i)  pwm_q <= apply_act(cfg_i.on_zero, pwm_q);
    else if (match_i) pwm_q <= apply_act(cfg_i.on_cmp, pwm_q);
  end

  // R7: no event, no change
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_i && !match_i) |=> $stable(pwm_q));
  // R8: zero action wins over a simultaneous compare
  a_r8_zero_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_i && cfg_i.on_zero == ACT_HIGH) |=> pwm_q);
  a_r8_zero_wins_low: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_i && cfg_i.on_zero == ACT_LOW) |=> !pwm_q);
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwmtb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int C_W   = 3,
  parameter int F_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CNT_W-1:0]    wr_data,
  output logic                pwm_a,
  output logic                pwm_b,
  output logic                zero_evt,
  output logic                cmpa_evt,
  output logic                cmpb_evt,
  output logic [CNT_W-1:0]    count_o
);
  localparam int F_LO = C_W;
  localparam int F_HI = C_W + F_W - 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic              run, shadow, tick, zero_hit;
  logic [CNT_W-1:0]  cnt;
  logic [NCH-1:0]    match, pwm;
  logic [NCH:0]      evt_q;

  assign run    = ctrl_q[CTRL_RUN_BIT];
  assign shadow = ctrl_q[CTRL_SHD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            ctrl_q <= '0;
    else if (wr_en && wr_addr == A_CTRL)   ctrl_q <= wr_data[CTRL_W-1:0];
  end

  pwmtb_prescale #(.C_W(C_W), .F_W(F_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .restart_i (wr_en && wr_addr == A_CNT),
    .coarse_i  (ctrl_q[C_W-1:0]),
    .fine_i    (ctrl_q[F_HI:F_LO]),
    .tick_o    (tick)
  );

  pwmtb_timebase #(.W(CNT_W)) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick),
    .run_i    (run),
    .shadow_i (shadow),
    .prd_wr_i (wr_en && wr_addr == A_PRD),
    .cnt_wr_i (wr_en && wr_addr == A_CNT),
    .wdata_i  (wr_data),
    .cnt_o    (cnt),
    .zero_o   (zero_hit)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CNT_W-1:0] cmp_q;
    aq_cfg_t          aq_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_q <= '0;
        aq_q  <= '{on_cmp: ACT_NONE, on_zero: ACT_NONE};
      end else if (wr_en) begin
        if (wr_addr == ADDR_W'(int'(A_CMPA) + ch)) cmp_q <= wr_data;
        if (wr_addr == ADDR_W'(int'(A_ACTA) + ch)) aq_q  <= aq_cfg_t'(wr_data[3:0]);
      end
    end

    assign match[ch] = tick && (cnt == cmp_q);

    pwmtb_aq u_aq (
      .clk     (clk),
      .rst_n   (rst_n),
      .zero_i  (zero_hit),
      .match_i (match[ch]),
      .cfg_i   (aq_q),
      .pwm_o   (pwm[ch])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= {match, zero_hit};
  end

  assign pwm_a    = pwm[0];
  assign pwm_b    = pwm[1];
  assign zero_evt = evt_q[0];
  assign cmpa_evt = evt_q[1];
  assign cmpb_evt = evt_q[2];
  assign count_o  = cnt;

  // R6: zero strobe follows an edge where the counter was 0
  a_r6_zero_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |-> $past(count_o) == '0);
  // R6: no strobe while frozen
  a_r6_no_strobe_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !zero_evt && !cmpa_evt && !cmpb_evt);
endmodule

// File: tb/pwm_timebase_bench.sv
module pwm_timebase_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_a, pwm_b, zero_evt, cmpa_evt, cmpb_evt;
  logic [15:0] count_o;

  int n_vec = 0;
  int n_bad = 0;
  string cur_req = "R1";

  // behavioural model state
  int m_cnt = 0, m_pre = 0, m_prd = 0, m_shd = 0, m_ca = 0, m_cb = 0;
  int m_cd = 0, m_fd = 0, m_run = 0, m_sh = 0;
  int m_aza = 0, m_aca = 0, m_azb = 0, m_acb = 0;
  int m_pa = 0, m_pb = 0, m_ez = 0, m_ea = 0, m_eb = 0;

  always #(CLK_P/2) clk = ~clk;

  pwm_timebase u_pwm_timebase (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .zero_evt(zero_evt), .cmpa_evt(cmpa_evt),
    .cmpb_evt(cmpb_evt), .count_o(count_o)
  );

  function automatic int act(int code, int cur);
    case (code)
      1: return 0;
      2: return 1;
      3: return cur ^ 1;
      default: return cur;
    endcase
  endfunction

  task automatic check();
    n_vec++;
    if (count_o !== 16'(m_cnt) || pwm_a !== 1'(m_pa) || pwm_b !== 1'(m_pb) ||
        zero_evt !== 1'(m_ez) || cmpa_evt !== 1'(m_ea) || cmpb_evt !== 1'(m_eb)) begin
      n_bad++;
      $display("FAIL %s: cnt/a/b/z/ea/eb actual %0d/%0b/%0b/%0b/%0b/%0b expected %0d/%0d/%0d/%0d/%0d/%0d",
               cur_req, count_o, pwm_a, pwm_b, zero_evt, cmpa_evt, cmpb_evt,
               m_cnt, m_pa, m_pb, m_ez, m_ea, m_eb);
    end
  endtask

  task automatic model(input bit we, input int a, input int d);
    int n, tick, z, ea, eb, npre, ncnt, nprd;
    n    = (1 << m_cd) * ((m_fd == 0) ? 1 : 2 * m_fd);
    tick = (m_run != 0 && m_pre >= n - 1) ? 1 : 0;
    z    = (tick != 0 && m_cnt == 0) ? 1 : 0;
    ea   = (tick != 0 && m_cnt == m_ca) ? 1 : 0;
    eb   = (tick != 0 && m_cnt == m_cb) ? 1 : 0;
    npre = (m_run == 0 || (we && a == 4) || tick != 0) ? 0 : m_pre + 1;
    if (we && a == 4)  ncnt = d;
    else if (tick != 0) ncnt = (m_cnt == m_prd) ? 0 : (m_cnt + 1) & 16'hFFFF;
    else               ncnt = m_cnt;
    if (we && a == 1 && m_sh == 0) nprd = d;
    else if (z != 0 && m_sh != 0)  nprd = m_shd;
    else                           nprd = m_prd;
    if (z != 0) begin
      m_pa = act(m_aza, m_pa);
      m_pb = act(m_azb, m_pb);
    end else begin
      if (ea != 0) m_pa = act(m_aca, m_pa);
      if (eb != 0) m_pb = act(m_acb, m_pb);
    end
    m_ez = z; m_ea = ea; m_eb = eb;
    m_pre = npre; m_cnt = ncnt; m_prd = nprd;
    if (we) begin
      case (a)
        0: begin m_cd = d & 7; m_fd = (d >> 3) & 7; m_run = (d >> 6) & 1; m_sh = (d >> 7) & 1; end
        1: m_shd = d;
        2: m_ca = d;
        3: m_cb = d;
        5: begin m_aza = d & 3; m_aca = (d >> 2) & 3; end
        6: begin m_azb = d & 3; m_acb = (d >> 2) & 3; end
        default: ;
      endcase
    end
  endtask

  task automatic step(input bit we, input int a, input int d);
    check();
    wr_en = we; wr_addr = a[2:0]; wr_data = d[15:0];
    model(we, a, d);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, frozen
    cur_req = "R1"; idle(4);
    // R3 R6 R7: period 9, compare 3 and 6, high at zero, toggle on compare
    cur_req = "R7";
    step(1, 1, 9); step(1, 2, 3); step(1, 3, 6);
    step(1, 5, 'hE); step(1, 6, 'hE); step(1, 4, 0);
    cur_req = "R3"; step(1, 0, 'h40); idle(40);
    // R2: divide 2 * 6 = 12, then 2
    cur_req = "R2"; step(1, 0, 'h59); idle(300);
    step(1, 0, 'h48); idle(60);
    step(1, 0, 'h07); idle(10);
    step(1, 0, 'h47); idle(600);
    // R4: freeze holds
    cur_req = "R4"; step(1, 0, 'h00); idle(20);
    // R5: direct write while frozen and while running
    cur_req = "R5"; step(1, 4, 5); idle(5);
    step(1, 0, 'h40); idle(7); step(1, 4, 2); idle(25);
    // R6: distinct compare placements
    cur_req = "R6"; step(1, 2, 9); step(1, 3, 1); idle(30);
    // R7: disabled configuration, low at zero
    cur_req = "R7"; step(1, 5, 'hD); step(1, 6, 'h1); idle(30);
    // R8: compare on zero, zero action only
    cur_req = "R8"; step(1, 2, 0); step(1, 5, 'hE); step(1, 3, 0); step(1, 6, 'h7); idle(30);
    // R9: shadowed period write
    cur_req = "R9"; step(1, 2, 3); step(1, 3, 6); step(1, 6, 'hE);
    step(1, 0, 'hC0); idle(3); step(1, 1, 4); idle(40);
    // R10: immediate period write
    cur_req = "R10"; step(1, 0, 'h40); idle(2); step(1, 1, 20); idle(60);
    step(1, 1, 7); idle(30);
    check();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule